// File: doc/BRIEF.md
# Interval Timer Register Interface

This block is the byte-wide programming and readback front end for a bank of interval timer channels. The default is three. A 2-bit address selects one of them. The low addresses are the per-channel data ports, and the highest address is the command port. A command byte either sets a channel's configuration or asks for a snapshot. The configuration is a byte access pattern, an operating mode and a decimal flag. The snapshot can be of one channel's count, or of count and status across several channels at once.

The counting logic lives outside this block. Each channel receives a one-cycle load strobe with a 16-bit reload value and its configured mode and decimal flag. In return, each channel supplies its live count and its output level. The block assembles 16-bit reloads from byte writes. It returns live or frozen counts one byte at a time, in an order set by the access pattern, and a pending status byte is always returned ahead of any count.

Top module: `tmr_regif`

## Requirements
- R1: After reset every channel uses two-byte access (code 3), mode 3 and decimal flag 0, with no latched count or status pending; `mode_o` and `bcd_o` show this.
- R2: A command write has its target in bits 7:6, with values 0..2 naming a channel. When bits 5:4 of that write are nonzero, the named channel takes its access code from bits 5:4, its mode from bits 3:1 and its decimal flag from bit 0. The same write restarts that channel's write and read byte order at the low byte.
- R3: With access code 1, a data write loads `{8'h00, byte}`. With access code 2, it loads `{byte, 8'h00}`. In both cases the load strobe is high for exactly the cycle after the write.
- R4: With access code 3, the first data write is only held, and the second loads `{second, first}`. A reconfiguring command write between the two discards the held byte.
- R5: A command write with bits 5:4 equal to 0 freezes that channel's live count. The request is ignored while an earlier frozen count is still unread.
- R6: A command write with bits 7:6 equal to 3 is a group snapshot. Bits 1, 2 and 3 pick channels 0, 1 and 2. Bit 5 low freezes the count of each picked channel. Bit 4 low captures the status of each picked channel, except where a status is already pending.
- R7: The status byte is {output level, 0, access code, mode, decimal flag} at bits 7, 6, 5:4, 3:1 and 0, sampled when captured.
- R8: A data read returns a pending status first, then a pending frozen count, and otherwise the live count. A status clears after one read, and a frozen count clears once all of its bytes have been read.
- R9: Live reads return the low byte for access code 1 and the high byte for access code 2. For access code 3, successive live reads alternate low, high, starting with low.
- R10: A frozen count is read back as the access code at freeze time dictates: the low byte only for code 1, the high byte only for code 2, and low then high for code 3.
- R11: A read at the command address returns 0 and changes no channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe |
| addr_i | input | 2 | Port address; NCH..3 = command |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, valid while rd_en_i is high |
| cnt_live_i | input | 48 | Live count per channel, 16 bits each |
| out_live_i | input | 3 | Output level per channel |
| load_o | output | 3 | One-cycle reload strobe per channel |
| load_val_o | output | 48 | Reload value per channel |
| mode_o | output | 9 | Configured mode per channel, 3 bits each |
| bcd_o | output | 3 | Decimal flag per channel |

## Verification
The assertions check several properties on every cycle. A reload strobe never appears without a data write in the cycle before. A two-byte reload only completes from the high-byte phase. A frozen count stays fixed until it is read. A status read retires the status without touching the frozen count. A captured status never carries access code 0. Other behaviour needs the bench's scenarios: the exact byte values returned in priority order, ignoring a second freeze, group snapshots across several channels, status that is kept while one is pending, and a reconfiguration that discards a half-written reload. All of these depend on sequences of bus operations and on expected data values.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  typedef struct packed {
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } chan_cfg_t;

  localparam logic [2:0] RST_MODE = 3'd3;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import tmr_regif_pkg::*;
#(
  parameter int unsigned NCH    = 3,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [NCH-1:0]    cfg_we_o,
  output logic [NCH-1:0]    cnt_latch_o,
  output logic [NCH-1:0]    sts_latch_o,
  output logic [NCH-1:0]    data_we_o,
  output logic [NCH-1:0]    data_re_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = {ADDR_W{1'b1}};
  localparam logic [1:0]        GROUP_SEL = 2'd3;

  logic       is_cmd;
  logic [1:0] tgt;
  acc_e       acc;
  logic       group;

  assign is_cmd = wr_en_i && (addr_i == CTRL_ADDR);
  assign tgt    = wdata_i[7:6];
  assign acc    = acc_e'(wdata_i[5:4]);
  assign group  = (tgt == GROUP_SEL);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [1:0]        CH_ID = 2'(g);
    localparam logic [ADDR_W-1:0] CH_AD = ADDR_W'(g);
    logic named;
    logic picked;
    assign named  = is_cmd && !group && (tgt == CH_ID);
    // group snapshot: channel g is picked by bit g+1
    assign picked = is_cmd && group && wdata_i[g+1];

    assign cfg_we_o[g]    = named && (acc != ACC_LATCH);
    assign cnt_latch_o[g] = (named && (acc == ACC_LATCH)) || (picked && !wdata_i[5]);
    assign sts_latch_o[g] = picked && !wdata_i[4];
    assign data_we_o[g]   = wr_en_i && (addr_i == CH_AD);
    assign data_re_o[g]   = rd_en_i && (addr_i == CH_AD);
  end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
  import tmr_regif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cnt_latch_i,
  input  logic              sts_latch_i,
  input  logic              data_we_i,
  input  logic              data_re_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_live_i,
  input  logic              out_live_i,
  output logic [BYTE_W-1:0] rbyte_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output chan_cfg_t         cfg_o
);
  chan_cfg_t         cfg_q, cfg_new;
  logic              wr_hi_q, rd_hi_q;
  logic [BYTE_W-1:0] hold_q;
  logic              load_q;
  logic [CNT_W-1:0]  load_val_q;
  logic              lat_vld_q, lat_hi_q;
  acc_e              lat_acc_q;
  logic [CNT_W-1:0]  lat_val_q;
  logic              sts_vld_q;
  logic [BYTE_W-1:0] sts_q;

  assign cfg_new = chan_cfg_t'(wdata_i[5:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '{acc: ACC_WORD, mode: RST_MODE, bcd: 1'b0};
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      hold_q     <= '0;
      load_q     <= 1'b0;
      load_val_q <= '0;
      lat_vld_q  <= 1'b0;
      lat_hi_q   <= 1'b0;
      lat_acc_q  <= ACC_WORD;
      lat_val_q  <= '0;
      sts_vld_q  <= 1'b0;
      sts_q      <= '0;
    end else begin
      load_q <= 1'b0;
      if (cfg_we_i) begin
        cfg_q   <= cfg_new;
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end
      if (data_we_i) begin
        unique case (cfg_q.acc)
          ACC_LO: begin
            load_q     <= 1'b1;
            load_val_q <= {{BYTE_W{1'b0}}, wdata_i};
          end
          ACC_HI: begin
            load_q     <= 1'b1;
            load_val_q <= {wdata_i, {BYTE_W{1'b0}}};
          end
          default: begin
            if (!wr_hi_q) begin
              hold_q  <= wdata_i;
              wr_hi_q <= 1'b1;
            end else begin
              load_q     <= 1'b1;
              load_val_q <= {wdata_i, hold_q};
              wr_hi_q    <= 1'b0;
            end
          end
        endcase
      end
      // latch once: a pending frozen count blocks a new one
      if (cnt_latch_i && !lat_vld_q) begin
        lat_vld_q <= 1'b1;
        lat_hi_q  <= 1'b0;
        lat_acc_q <= cfg_q.acc;
        lat_val_q <= cnt_live_i;
      end
      if (sts_latch_i && !sts_vld_q) begin
        sts_vld_q <= 1'b1;
        sts_q     <= {out_live_i, 1'b0, cfg_q.acc, cfg_q.mode, cfg_q.bcd};
      end
      if (data_re_i) begin
        if (sts_vld_q) begin
          sts_vld_q <= 1'b0;
        end else if (lat_vld_q) begin
          if (lat_acc_q == ACC_WORD && !lat_hi_q) begin
            lat_hi_q <= 1'b1;
          end else begin
            lat_vld_q <= 1'b0;
            lat_hi_q  <= 1'b0;
          end
        end else if (cfg_q.acc == ACC_WORD) begin
          rd_hi_q <= !rd_hi_q;
        end
      end
    end
  end

  always_comb begin
    if (sts_vld_q) begin
      rbyte_o = sts_q;
    end else if (lat_vld_q) begin
      unique case (lat_acc_q)
        ACC_HI:   rbyte_o = lat_val_q[CNT_W-1:BYTE_W];
        ACC_WORD: rbyte_o = lat_hi_q ? lat_val_q[CNT_W-1:BYTE_W] : lat_val_q[BYTE_W-1:0];
        default:  rbyte_o = lat_val_q[BYTE_W-1:0];
      endcase
    end else begin
      unique case (cfg_q.acc)
        ACC_HI:   rbyte_o = cnt_live_i[CNT_W-1:BYTE_W];
        ACC_WORD: rbyte_o = rd_hi_q ? cnt_live_i[CNT_W-1:BYTE_W] : cnt_live_i[BYTE_W-1:0];
        default:  rbyte_o = cnt_live_i[BYTE_W-1:0];
      endcase
    end
  end

  assign load_o     = load_q;
  assign load_val_o = load_val_q;
  assign cfg_o      = cfg_q;

  // R3
  load_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> $past(data_we_i));

  // R4
  word_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && $past(cfg_q.acc) == ACC_WORD) |-> $past(wr_hi_q));

  // R5
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_vld_q && !data_re_i) |=> $stable(lat_val_q));

  // R8
  sts_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_re_i && sts_vld_q) |=> (!sts_vld_q && $stable(lat_vld_q) && $stable(lat_hi_q)));

  // R7
  sts_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_vld_q |-> (sts_q[5:4] != 2'b00));
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_regif_pkg::*;
#(
  parameter int unsigned NCH    = 3,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BYTE_W-1:0]    wdata_i,
  output logic [BYTE_W-1:0]    rdata_o,
  input  logic [NCH*CNT_W-1:0] cnt_live_i,
  input  logic [NCH-1:0]       out_live_i,
  output logic [NCH-1:0]       load_o,
  output logic [NCH*CNT_W-1:0] load_val_o,
  output logic [NCH*3-1:0]     mode_o,
  output logic [NCH-1:0]       bcd_o
);
  logic [NCH-1:0]        cfg_we, cnt_latch, sts_latch, data_we, data_re;
  logic [BYTE_W-1:0]     rbyte [NCH];

  tmr_cmd_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .cfg_we_o    (cfg_we),
    .cnt_latch_o (cnt_latch),
    .sts_latch_o (sts_latch),
    .data_we_o   (data_we),
    .data_re_o   (data_re)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    chan_cfg_t cfg;
    tmr_chan_port u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_we_i    (cfg_we[g]),
      .cnt_latch_i (cnt_latch[g]),
      .sts_latch_i (sts_latch[g]),
      .data_we_i   (data_we[g]),
      .data_re_i   (data_re[g]),
      .wdata_i     (wdata_i),
      .cnt_live_i  (cnt_live_i[g*CNT_W +: CNT_W]),
      .out_live_i  (out_live_i[g]),
      .rbyte_o     (rbyte[g]),
      .load_o      (load_o[g]),
      .load_val_o  (load_val_o[g*CNT_W +: CNT_W]),
      .cfg_o       (cfg)
    );
    assign mode_o[g*3 +: 3] = cfg.mode;
    assign bcd_o[g]         = cfg.bcd;
  end

  // command address and unused channel addresses read as zero
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (data_re[i]) rdata_o = rbyte[i];
    end
  end

  // R11
  rd_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(data_re));
endmodule

// File: tb/tmr_regif_bench.sv
module tmr_regif_bench;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] cnt_live = '0;
  logic [2:0]  out_live = '0;
  logic [2:0]  load;
  logic [47:0] load_val;
  logic [8:0]  mode;
  logic [2:0]  bcd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]  exp_rd_q[$];
  string       req_rd_q[$];
  logic [17:0] exp_ld_q[$];

  always #2.5 clk = ~clk;

  tmr_regif u_tmr_regif (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .cnt_live_i(cnt_live), .out_live_i(out_live),
    .load_o(load), .load_val_o(load_val), .mode_o(mode), .bcd_o(bcd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compares design results against the scoreboard queues
  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      if (exp_rd_q.size() == 0) chk("R8 unexpected read", 32'(rdata), 32'hFFFF_FFFF);
      else begin
        automatic logic [7:0] e = exp_rd_q.pop_front();
        automatic string r = req_rd_q.pop_front();
        chk(r, 32'(rdata), 32'(e));
      end
    end
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        if (load[c]) begin
          if (exp_ld_q.size() == 0) chk("R3/R4 stray load", 32'({2'(c), load_val[c*16 +: 16]}), 32'hFFFF_FFFF);
          else chk("R3/R4 load", 32'({2'(c), load_val[c*16 +: 16]}), 32'(exp_ld_q.pop_front()));
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string req);
    exp_rd_q.push_back(e);
    req_rd_q.push_back(req);
    @(posedge clk); #1;
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  function automatic void exp_load(input int c, input logic [15:0] v);
    exp_ld_q.push_back({2'(c), v});
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cnt_live = {16'h9ABC, 16'h5678, 16'h1234};
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset configuration
    chk("R1 mode0", 32'(mode[2:0]), 32'd3);
    chk("R1 mode2", 32'(mode[8:6]), 32'd3);
    chk("R1 bcd", 32'(bcd), 32'd0);
    // R9 two-byte live read alternates low then high
    rd(2'd0, 8'h34, "R1/R9 live lo");
    rd(2'd0, 8'h12, "R9 live hi");

    // R2 R4 two-byte reload on ch0, mode 2
    wr(2'd3, 8'h34);
    chk("R2 mode0", 32'(mode[2:0]), 32'd2);
    wr(2'd0, 8'hCD);
    exp_load(0, 16'hABCD);
    wr(2'd0, 8'hAB);

    // R3 low-only reload on ch1
    wr(2'd3, 8'h50);
    exp_load(1, 16'h0077);
    wr(2'd1, 8'h77);
    rd(2'd1, 8'h78, "R9 lo only");
    rd(2'd1, 8'h78, "R9 lo only repeat");

    // R3 high-only reload on ch2, mode 4, decimal flag
    wr(2'd3, 8'hA9);
    chk("R2 mode2", 32'(mode[8:6]), 32'd4);
    chk("R2 bcd2", 32'(bcd[2]), 32'd1);
    exp_load(2, 16'h4200);
    wr(2'd2, 8'h42);
    rd(2'd2, 8'h9A, "R9 hi only");

    // R5 freeze, second freeze ignored while pending
    wr(2'd3, 8'h00);
    cnt_live[15:0] = 16'h2211;
    wr(2'd3, 8'h00);
    rd(2'd0, 8'h34, "R5/R10 frozen lo");
    rd(2'd0, 8'h12, "R5/R10 frozen hi");
    rd(2'd0, 8'h11, "R8 live after frozen");
    rd(2'd0, 8'h22, "R9 live hi");

    // R6 R7 group snapshot count+status on ch0
    out_live = 3'b101;
    wr(2'd3, 8'hC2);
    rd(2'd0, 8'hB4, "R7/R8 status first");
    rd(2'd0, 8'h11, "R6 frozen lo");
    rd(2'd0, 8'h22, "R6 frozen hi");

    // R6 status only on ch1 and ch2
    wr(2'd3, 8'hEC);
    rd(2'd1, 8'h10, "R7 status ch1");
    rd(2'd1, 8'h78, "R6 no count frozen ch1");
    rd(2'd2, 8'hA9, "R7 status ch2");
    rd(2'd2, 8'h9A, "R6 no count frozen ch2");

    // R6 pending status is kept
    wr(2'd3, 8'hE4);
    out_live[1] = 1'b1;
    wr(2'd3, 8'hE4);
    rd(2'd1, 8'h10, "R6 status kept");
    rd(2'd1, 8'h78, "R8 status cleared");

    // R4 reconfiguration discards held byte
    wr(2'd3, 8'h34);
    wr(2'd0, 8'h55);
    wr(2'd3, 8'h34);
    exp_load(0, 16'h7766);
    wr(2'd0, 8'h66);
    wr(2'd0, 8'h77);

    // R11 command address read is zero and inert
    wr(2'd3, 8'h00);
    rd(2'd3, 8'h00, "R11 cmd read");
    rd(2'd0, 8'h11, "R11 frozen lo intact");
    rd(2'd3, 8'h00, "R11 cmd read");
    rd(2'd0, 8'h22, "R11 frozen hi intact");
    rd(2'd0, 8'h11, "R8 live lo after clear");

    // R10 low-only frozen count returns one byte
    wr(2'd3, 8'h40);
    cnt_live[31:16] = 16'h0102;
    rd(2'd1, 8'h78, "R10 frozen lo only");
    rd(2'd1, 8'h02, "R10 cleared after one");

    // R10 high-only frozen count
    wr(2'd3, 8'h80);
    cnt_live[47:32] = 16'h0000;
    rd(2'd2, 8'h9A, "R10 frozen hi only");
    rd(2'd2, 8'h00, "R10 cleared hi");

    repeat (4) @(posedge clk);
    chk("R3/R4 loads pending", 32'(exp_ld_q.size()), 32'd0);
    chk("R8 reads pending", 32'(exp_rd_q.size()), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule